// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Boundary-Aligned Reload

This block drives a set of independent pulse-width modulated outputs from a small synchronous register bus. Each channel counts prescaled clock ticks through a programmable period. For the first part of each period its output sits at a programmable active level, and for the rest at a separately programmable inactive level. The prescaler divides the input clock by a power of two that a three-bit code picks from a fixed, nonlinear table.

Each channel has an enable bit in one shared control word. That word can be written directly, or through three alias addresses that set, clear or toggle the bits written as 1. Software writes a channel's high-time word first and its configuration word second. Both are held as pending. The configuration write arms a reload, and the pair moves into the running copy only when the current period finishes, so no output ever carries a truncated or stretched pulse. Enabling a channel loads the pending values at once and starts a fresh period. A disabled channel holds its counter at zero and drives its inactive level.

Top module: `pwm_bank`

## Requirements
- R1: The control word lives at 0x00, and bit n enables channel n. A write to 0x00 replaces it. A write to 0x04 sets the 1-bits of the data, 0x08 clears them and 0x0C inverts them, leaving the other bits unchanged. All four addresses read back the current control word, and bits at and above the channel count read 0.
- R2: Channel n's high-time word is at 0x10 + 0x20*n, with the count in bits 31:16. Its configuration word is at 0x20 + 0x20*n, with period in bits 15:0, active level in 17:16, inactive level in 19:18 and prescaler code in 22:20. Reads return the last written field values with all other bits 0. Unmapped or misaligned addresses read 0 and ignore writes.
- R3: Prescaler codes 0 to 7 make one count last 1, 2, 4, 8, 16, 64, 256 and 1024 input clocks respectively.
- R4: A running channel's period lasts max(period,1) counts. Its output takes the active level during the first high-time counts of each period and the inactive level for the rest.
- R5: A level field of 3 drives high. Fields of 2, 1 and 0 drive low. The active and inactive fields act independently, so either polarity can be produced.
- R6: A high-time of 0 gives a constant inactive level. A high-time at or above the period gives a constant active level.
- R7: When a channel's enable bit goes from 0 to 1 at clock edge E, the pending values are loaded and count 0 of a new period starts at edge E+1.
- R8: When a channel's enable bit is 0, its counter is zero from the next edge on, and its output drives the inactive level of the last configuration written, one clock after that write.
- R9: A high-time write on its own, without a following configuration write, never changes a running channel's waveform.
- R10: A configuration write at edge W makes both pending words take effect together at the first period boundary strictly after W. Before that boundary the old waveform continues unchanged. The new period starts with count 0 at the boundary.
- R11: After reset the control word and all channel words read 0, and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and all channels |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | AW (8) | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH (4) | One modulated output per channel |

## Verification
A write takes effect at the edge where bus_we is sampled. Read data is combinational, so the bench sets the address on a falling edge and samples one nanosecond later. An enable written at edge E puts count 0 on the output after edge E+1. The bench therefore samples every falling edge from that point and compares each sample against an arithmetic model indexed by the number of clocks since E+1. For reloads, the bench records the edge number of the configuration write and computes the first period boundary after it from the old period and prescale. It then expects the old waveform strictly before that boundary and the new one, re-indexed from zero, after it. The disabled-level check waits two clocks after the write, allowing for the one clock through which the inactive level follows the pending copy.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int DW    = 32;
  localparam int CNT_W = 16;
  localparam int PRE_W = 10;

  // Field order matches the configuration word bits 22:0
  typedef struct packed {
    logic [2:0]       div;
    logic [1:0]       ilvl;
    logic [1:0]       alvl;
    logic [CNT_W-1:0] per;
  } pwm_cfg_t;

  localparam int CFG_W = $bits(pwm_cfg_t);

  // Prescaler code to shift amount: linear up to 4, then steps of two
  function automatic logic [3:0] div_shift(input logic [2:0] code);
    case (code)
      3'd5:    return 4'd6;
      3'd6:    return 4'd8;
      3'd7:    return 4'd10;
      default: return {1'b0, code};
    endcase
  endfunction

  // Terminal value of the prescaler for a code
  function automatic logic [PRE_W-1:0] pre_limit(input logic [2:0] code);
    logic [PRE_W:0] t;
    t = ((PRE_W+1)'(1) << div_shift(code)) - (PRE_W+1)'(1);
    return t[PRE_W-1:0];
  endfunction

  function automatic logic drive_level(input logic [1:0] enc);
    return enc == 2'b11;
  endfunction

  // True on the last count of a period (period 0 behaves as 1)
  function automatic logic last_count(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] per);
    return ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, per};
  endfunction

  function automatic logic in_active(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] act);
    return cnt < act;
  endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_we,
  input  logic [AW-1:0]               bus_addr,
  input  logic [DW-1:0]               bus_wdata,
  output logic [DW-1:0]               bus_rdata,
  output logic [NCH-1:0]              ctrl_q,
  output logic [NCH-1:0][CNT_W-1:0]   pend_act,
  output pwm_cfg_t [NCH-1:0]          pend_cfg,
  output logic [NCH-1:0]              per_wr
);

  localparam int SLOT_LSB = 5;
  localparam int SLOT_W   = AW - SLOT_LSB;

  logic              aligned;
  logic              ctrl_hit;
  logic [SLOT_W-1:0] slot;
  logic [NCH-1:0]    act_hit;
  logic [NCH-1:0]    per_hit;

  assign aligned  = bus_addr[1:0] == 2'b00;
  assign ctrl_hit = aligned && (bus_addr[AW-1:4] == '0);
  assign slot     = bus_addr[AW-1:SLOT_LSB];

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign act_hit[g] = aligned && (bus_addr[4:2] == 3'b100) &&
                        (slot == SLOT_W'(g));
    assign per_hit[g] = aligned && (bus_addr[4:2] == 3'b000) &&
                        (slot == SLOT_W'(g + 1));
  end

  assign per_wr = bus_we ? per_hit : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      pend_act <= '0;
      pend_cfg <= '0;
    end else if (bus_we) begin
      if (ctrl_hit) begin
        case (bus_addr[3:2])
          2'd0: ctrl_q <= bus_wdata[NCH-1:0];
          2'd1: ctrl_q <= ctrl_q | bus_wdata[NCH-1:0];
          2'd2: ctrl_q <= ctrl_q & ~bus_wdata[NCH-1:0];
          default: ctrl_q <= ctrl_q ^ bus_wdata[NCH-1:0];
        endcase
      end
      for (int i = 0; i < NCH; i++) begin
        if (act_hit[i]) pend_act[i] <= bus_wdata[DW-1:DW-CNT_W];
        if (per_hit[i]) pend_cfg[i] <= pwm_cfg_t'(bus_wdata[CFG_W-1:0]);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (ctrl_hit) bus_rdata = DW'(ctrl_q);
    for (int i = 0; i < NCH; i++) begin
      if (act_hit[i]) bus_rdata = {pend_act[i], {(DW-CNT_W){1'b0}}};
      if (per_hit[i]) bus_rdata = DW'(pend_cfg[i]);
    end
  end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] pend_act,
  input  pwm_cfg_t         pend_cfg,
  input  logic             per_wr,
  output logic             pwm_out,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             per_end_o,
  output pwm_cfg_t         cfg_o,
  output logic [CNT_W-1:0] act_o
);

  logic             run_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_q;
  pwm_cfg_t         cfg_q;
  logic [PRE_W-1:0] pre_q;

  logic tick;
  logic per_end;
  logic commit;

  assign tick    = run_q && (pre_q == pre_limit(cfg_q.div));
  assign per_end = tick && last_count(cnt_q, cfg_q.per);
  assign commit  = per_end && armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pre_q   <= '0;
      act_q   <= '0;
      cfg_q   <= '0;
    end else if (!en) begin
      // Idle: follow the pending copy so the inactive level is current
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pre_q   <= '0;
      act_q   <= pend_act;
      cfg_q   <= pend_cfg;
    end else if (!run_q) begin
      // Start of a fresh period on enable
      run_q   <= 1'b1;
      armed_q <= per_wr;
      cnt_q   <= '0;
      pre_q   <= '0;
      act_q   <= pend_act;
      cfg_q   <= pend_cfg;
    end else begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (per_end)   cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + CNT_W'(1);
      if (commit) begin
        act_q <= pend_act;
        cfg_q <= pend_cfg;
      end
      if (per_wr)      armed_q <= 1'b1;
      else if (commit) armed_q <= 1'b0;
    end
  end

  assign pwm_out = (run_q && in_active(cnt_q, act_q)) ?
                   drive_level(cfg_q.alvl) : drive_level(cfg_q.ilvl);

  assign run_o     = run_q;
  assign cnt_o     = cnt_q;
  assign per_end_o = per_end;
  assign cfg_o     = cfg_q;
  assign act_o     = act_q;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out
);

  logic [NCH-1:0]            ctrl_en;
  logic [NCH-1:0][CNT_W-1:0] pend_act;
  pwm_cfg_t [NCH-1:0]        pend_cfg;
  logic [NCH-1:0]            per_wr;

  // Per-channel events brought out for the checker
  logic [NCH-1:0]            ch_run;
  logic [NCH-1:0][CNT_W-1:0] ch_cnt;
  logic [NCH-1:0]            ch_end;
  pwm_cfg_t [NCH-1:0]        ch_cfg;
  logic [NCH-1:0][CNT_W-1:0] ch_act;

  pwm_bank_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_q    (ctrl_en),
    .pend_act  (pend_act),
    .pend_cfg  (pend_cfg),
    .per_wr    (per_wr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_bank_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctrl_en[g]),
      .pend_act  (pend_act[g]),
      .pend_cfg  (pend_cfg[g]),
      .per_wr    (per_wr[g]),
      .pwm_out   (pwm_out[g]),
      .run_o     (ch_run[g]),
      .cnt_o     (ch_cnt[g]),
      .per_end_o (ch_end[g]),
      .cfg_o     (ch_cfg[g]),
      .act_o     (ch_act[g])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_we,
  input logic [AW-1:0]             bus_addr,
  input logic [31:0]               bus_wdata,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0]            ctrl_en,
  input logic [NCH-1:0]            ch_run,
  input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NCH-1:0]            ch_end,
  input pwm_cfg_t [NCH-1:0]        ch_cfg,
  input logic [NCH-1:0][CNT_W-1:0] ch_act
);

  a_r1_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == AW'('h8) |=>
      ctrl_en == ($past(ctrl_en) & ~$past(bus_wdata[NCH-1:0])));

  a_r1_toggle_alias: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == AW'('hC) |=>
      ctrl_en == ($past(ctrl_en) ^ $past(bus_wdata[NCH-1:0])));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r4_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      ch_run[g] |-> ((ch_cfg[g].per <= CNT_W'(1)) ? (ch_cnt[g] == '0)
                                                 : (ch_cnt[g] < ch_cfg[g].per)));

    a_r6_zero_high_time: assert property (@(posedge clk) disable iff (!rst_n)
      ch_run[g] && ch_act[g] == '0 |-> pwm_out[g] == (ch_cfg[g].ilvl == 2'b11));

    a_r7_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_en[g] && !ch_run[g] |=> ch_run[g] && ch_cnt[g] == '0);

    a_r8_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en[g] |=> !ch_run[g] && ch_cnt[g] == '0);

    a_r10_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
      ch_run[g] && ctrl_en[g] && !ch_end[g] |=>
        $stable(ch_cfg[g]) && $stable(ch_act[g]));
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pwm_out   (pwm_out),
  .ctrl_en   (ctrl_en),
  .ch_run    (ch_run),
  .ch_cnt    (ch_cnt),
  .ch_end    (ch_end),
  .ch_cfg    (ch_cfg),
  .ch_act    (ch_act)
);

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;

  localparam int NCH = 4;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  wire  [31:0]   bus_rdata;
  wire  [NCH-1:0] pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_bank #(.NCH(NCH), .AW(AW)) i_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // ---------------- model ----------------
  function automatic int shamt(input int code);
    return (code < 5) ? code : 2 * code - 4;
  endfunction

  function automatic logic lvl(input int enc);
    return enc == 3;
  endfunction

  function automatic logic exp_out(input int act, input int per, input int code,
                                   input int al, input int il, input int idx);
    int p, l, k;
    p = 1 << shamt(code);
    l = (per == 0) ? 1 : per;
    k = (idx / p) % l;
    return (k < act) ? lvl(al) : lvl(il);
  endfunction

  function automatic logic [31:0] cfg_word(input int per, input int code,
                                           input int al, input int il);
    return (32'(code) << 20) | (32'(il) << 18) | (32'(al) << 16) | 32'(per);
  endfunction

  function automatic logic [AW-1:0] act_addr(input int ch);
    return AW'(16 + 32 * ch);
  endfunction

  function automatic logic [AW-1:0] cfg_addr(input int ch);
    return AW'(32 + 32 * ch);
  endfunction

  // ---------------- bus and check helpers ----------------
  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, output int edge_no);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    edge_no = cyc;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Program a channel, enable it and compare two full periods cycle by cycle
  task automatic run_cfg(input string req, input int ch, input int act, input int per,
                         input int code, input int al, input int il);
    int e, bad, len;
    logic got, ex;
    wr(8'h08, 32'(1) << ch, e);
    wr(act_addr(ch), 32'(act) << 16, e);
    wr(cfg_addr(ch), cfg_word(per, code, al, il), e);
    @(negedge clk); @(negedge clk);
    chk("R8", $sformatf("idle level ch%0d", ch), 32'(pwm_out[ch]), 32'(lvl(il)));
    wr(8'h04, 32'(1) << ch, e);
    len = 2 * ((per == 0) ? 1 : per) * (1 << shamt(code));
    bad = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      got = pwm_out[ch];
      ex  = exp_out(act, per, code, al, il, cyc - (e + 1));
      if (got !== ex) bad++;
    end
    chk(req, $sformatf("wave ch%0d act=%0d per=%0d code=%0d al=%0d il=%0d mismatching samples",
                       ch, act, per, code, al, il), 32'(bad), 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    int e, w, s, b, bad;
    int pers [3];

    pers[0] = 1; pers[1] = 3; pers[2] = 5;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    rd(8'h00, d); chk("R11", "ctrl after reset", d, 32'h0);
    for (int c = 0; c < NCH; c++) begin
      rd(act_addr(c), d); chk("R11", $sformatf("act%0d after reset", c), d, 32'h0);
      rd(cfg_addr(c), d); chk("R11", $sformatf("cfg%0d after reset", c), d, 32'h0);
    end
    chk("R11", "outputs after reset", 32'(pwm_out), 32'h0);

    // R1: control word and its aliases
    wr(8'h00, 32'h5, e);
    for (int a = 0; a < 4; a++) begin
      rd(AW'(4 * a), d); chk("R1", $sformatf("ctrl readback at alias %0d", a), d, 32'h5);
    end
    wr(8'h04, 32'h2, e); rd(8'h00, d); chk("R1", "set alias", d, 32'h7);
    wr(8'h08, 32'h4, e); rd(8'h00, d); chk("R1", "clear alias", d, 32'h3);
    wr(8'h0C, 32'h9, e); rd(8'h00, d); chk("R1", "toggle alias", d, 32'hA);
    wr(8'h00, 32'hF0, e); rd(8'h0C, d); chk("R1", "bits above channel count", d, 32'h0);

    // R2: channel words, field masks, unmapped space
    wr(act_addr(3), 32'hABCD_1234, e);
    rd(act_addr(3), d); chk("R2", "act3 field only", d, 32'hABCD_0000);
    wr(cfg_addr(3), 32'hFFFF_FFFF, e);
    rd(cfg_addr(3), d); chk("R2", "cfg3 field only", d, 32'h007F_FFFF);
    wr(8'h14, 32'hFFFF_FFFF, e);
    rd(8'h14, d); chk("R2", "unmapped 0x14", d, 32'h0);
    rd(8'h90, d); chk("R2", "beyond last channel", d, 32'h0);
    wr(8'h11, 32'h1234_0000, e);
    rd(act_addr(0), d); chk("R2", "misaligned write ignored", d, 32'h0);

    // R4/R5/R6: sweep small periods, high times and polarities
    for (int code = 0; code < 3; code++)
      for (int pi = 0; pi < 3; pi++)
        for (int ai = 0; ai < 4; ai++) begin
          int p, a, inv;
          p = pers[pi];
          a = (ai == 0) ? 0 : (ai == 1) ? 2 : (ai == 2) ? p : p + 1;
          inv = (code + pi + ai) % 2;
          run_cfg((ai == 0 || ai >= 2) ? "R6" : "R4", (pi + ai) % NCH, a, p, code,
                  inv ? 2 : 3, inv ? 3 : 2);
        end
    run_cfg("R6", 0, 0, 0, 0, 3, 2);
    run_cfg("R6", 1, 1, 0, 1, 3, 2);

    // R3: every prescaler code
    for (int code = 0; code < 8; code++) run_cfg("R3", 1, 1, 2, code, 3, 2);

    // R5: low encodings 0 and 1 in either field
    run_cfg("R5", 2, 1, 2, 0, 1, 3);
    run_cfg("R5", 3, 1, 2, 0, 3, 0);
    run_cfg("R5", 0, 2, 3, 0, 0, 1);

    // R7/R9/R10: reload only at the period boundary after the configuration write
    wr(8'h08, 32'h4, e);
    wr(act_addr(2), 32'(2) << 16, e);
    wr(cfg_addr(2), cfg_word(4, 1, 3, 2), e);
    wr(8'h04, 32'h4, e);
    s = e + 1;
    @(negedge clk);
    chk("R7", "first sample after enable", 32'(pwm_out[2]), 32'(exp_out(2, 4, 1, 3, 2, cyc - s)));
    repeat (3) @(negedge clk);
    wr(act_addr(2), 32'(3) << 16, e);
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (pwm_out[2] !== exp_out(2, 4, 1, 3, 2, cyc - s)) bad++;
    end
    chk("R9", "high-time write alone leaves waveform", 32'(bad), 32'd0);
    repeat (3) @(negedge clk);
    wr(cfg_addr(2), cfg_word(6, 0, 2, 3), w);
    b = s + 8 * ((w - s) / 8 + 1);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cyc < b) begin
        if (pwm_out[2] !== exp_out(2, 4, 1, 3, 2, cyc - s)) bad++;
      end else begin
        if (pwm_out[2] !== exp_out(3, 6, 0, 2, 3, cyc - b)) bad++;
      end
    end
    chk("R10", "reload aligned to next boundary", 32'(bad), 32'd0);

    // R8: disable returns to the inactive level of the new configuration
    wr(8'h08, 32'h4, e);
    @(negedge clk);
    chk("R8", "disabled output inactive", 32'(pwm_out[2]), 32'(lvl(3)));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule